// File: doc/BRIEF.md
# Streaming SSD Stereo Disparity Pipeline

This block turns two synchronized 8-bit grayscale pixel streams, one from a left camera and one from a right camera, into a stream of disparity codes, one for each pixel pair. Each frame is handled as one long raster-ordered vector, starting at the upper-left pixel. For every history position the block takes a one-dimensional window of `WIN` consecutive left-stream pixels, where `WIN` is odd. It compares that window against `2*BETA` right-stream windows, each displaced by a candidate offset. The cost of each candidate is its sum of squared differences. The code of the cheapest candidate is reported.

The pipeline steps forward once per `pixel_valid` pulse and has five stages:

1. History shift registers.
2. Difference capture.
3. Time-shared squaring.
4. Window summation.
5. A comparator tree.

The core clock runs much faster than the pixel rate. The squaring stage therefore reuses a small pool of `NMUL` multipliers over several clock cycles inside each pixel period. A `start_of_frame` flag given with a pixel empties the history, so that pixel becomes the first of a new frame.

Top module: `ssd_disparity`

## Requirements
- R1: After reset, `disp_valid` is low and `disp` is 0 until results are produced.
- R2: For the history ending at pixel n of a frame, let the centre be k = n - (WIN-1)/2 - BETA + 1. The cost of offset j is the sum, over t = -(WIN-1)/2 .. (WIN-1)/2, of (L[k+t] - R[k+t+j])^2. L and R are the left and right pixels taken as unsigned 8-bit values. No cost wraps around, even with full-scale 0/255 contrast.
- R3: The candidate offsets are j = -BETA .. BETA-1. `disp` carries the code j+BETA of the candidate with the smallest cost. The code is unsigned and ceil(log2(2*BETA)) bits wide, which is 3 bits by default.
- R4: When several candidates share the smallest cost, the smallest code wins.
- R5: The result for the history ending at the pixel of pulse n appears in the cycle after the edge that samples pulse n+3. It is shown by a `disp_valid` pulse lasting exactly one cycle.
- R6: A result is marked valid only if at least D = WIN-1+2*BETA pixels of the current frame had been received when it was formed. D is 18 by default.
- R7: A pixel given with `start_of_frame` high clears both histories and becomes pixel 0 of a new frame.
- R8: Squaring uses `NMUL` multipliers over NRND = ceil(WIN*2*BETA/NMUL) clock cycles, which is 8 by default. Consecutive `pixel_valid` pulses must be at least NRND+1 cycles apart.
- R9: While `pixel_valid` is low, the pixel and frame inputs are ignored. `disp` holds its value and `disp_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, much faster than the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pixel_valid | input | 1 | One-cycle pulse: a new pixel pair is present |
| start_of_frame | input | 1 | Qualified by `pixel_valid`; this pixel starts a frame |
| left_pix | input | 8 | Left-stream intensity |
| right_pix | input | 8 | Right-stream intensity |
| disp_valid | output | 1 | One-cycle pulse: `disp` holds a new result |
| disp | output | $clog2(2*BETA) | Winning code j+BETA |

## Verification
The first kind of stimulus is random textured frames. They exercise the cost arithmetic and the choice of argmin across all candidates. The second kind is frames in which the right stream is an exact copy of the left stream shifted by a known offset. These give a single zero-cost winner, which separates correct right-stream indexing from indexing that is off by one. Flat frames make every candidate cost equal, so they show whether ties go to the lowest code. Alternating full-scale frames stress the cost width. A frame cut short by an early `start_of_frame` shows whether the history clear and the fill-count gating of `disp_valid` work. Random values driven on the pixel inputs between pulses show whether any input is sampled outside a step.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  localparam int PIX_W = 8;
  localparam int SQ_W  = 2 * PIX_W;

  typedef logic [PIX_W-1:0]        pix_t;
  typedef logic signed [PIX_W:0]   diff_t;
  typedef logic [SQ_W-1:0]         sq_t;

  // signed difference of two unsigned intensities
  function automatic diff_t pix_diff(input pix_t a, input pix_t b);
    return diff_t'({1'b0, a}) - diff_t'({1'b0, b});
  endfunction

  // square of a difference via its magnitude (fits SQ_W bits)
  function automatic sq_t square_mag(input diff_t d);
    pix_t m;
    m = d[PIX_W] ? pix_t'(-d) : pix_t'(d);
    return sq_t'(m) * sq_t'(m);
  endfunction
endpackage

// File: rtl/disp_hist.sv
module disp_hist
  import ssd_pkg::*;
#(
  parameter int D = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic sof,
  input  pix_t lpix,
  input  pix_t rpix,
  output pix_t lh [D],
  output pix_t rh [D],
  output logic full
);
  localparam int FW = $clog2(D + 1);

  logic [FW-1:0] fill;

  // shift by one place toward older slots, then newest pair lands in slot 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
      for (int i = 0; i < D; i++) begin
        lh[i] <= '0;
        rh[i] <= '0;
      end
    end else if (step) begin
      if (sof) begin
        for (int i = 1; i < D; i++) begin
          lh[i] <= '0;
          rh[i] <= '0;
        end
        fill <= FW'(1);
      end else begin
        for (int i = 1; i < D; i++) begin
          lh[i] <= lh[i-1];
          rh[i] <= rh[i-1];
        end
        if (fill != FW'(D)) fill <= fill + FW'(1);
      end
      lh[0] <= lpix;
      rh[0] <= rpix;
    end
  end

  assign full = (fill == FW'(D));

  // R7
  sof_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && sof) |=> (fill == FW'(1)));
endmodule

// File: rtl/disp_sq_engine.sv
module disp_sq_engine
  import ssd_pkg::*;
#(
  parameter int WIN  = 11,
  parameter int BETA = 4,
  parameter int NMUL = 12,
  parameter int D    = WIN - 1 + 2 * BETA,
  parameter int NC   = 2 * BETA,
  parameter int NPAIR = WIN * NC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic v_in,
  input  pix_t lh [D],
  input  pix_t rh [D],
  output sq_t  sq [NPAIR],
  output logic v_out,
  output logic busy
);
  localparam int NRND = (NPAIR + NMUL - 1) / NMUL;
  localparam int RW   = (NRND > 1) ? $clog2(NRND) : 1;
  localparam int IW   = $clog2(NRND * NMUL + 1);

  diff_t         diff_r [NPAIR];
  logic [RW-1:0] rnd;
  sq_t           mul_q  [NMUL];

  // stage 2: capture every left/right difference of the current history
  for (genvar c = 0; c < NC; c++) begin : g_cand
    for (genvar w = 0; w < WIN; w++) begin : g_win
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    diff_r[c*WIN+w] <= '0;
        else if (step) diff_r[c*WIN+w] <= pix_diff(lh[WIN+BETA-2-w], rh[WIN+2*BETA-2-w-c]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    v_out <= 1'b0;
    else if (step) v_out <= v_in;
  end

  // stage 3 sequencer: one round of NMUL squares per core cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      rnd  <= '0;
    end else if (step) begin
      busy <= 1'b1;
      rnd  <= '0;
    end else if (busy) begin
      rnd <= rnd + RW'(1);
      if (rnd == RW'(NRND - 1)) busy <= 1'b0;
    end
  end

  for (genvar m = 0; m < NMUL; m++) begin : g_mul
    logic [IW-1:0] idx;
    diff_t         op;
    always_comb begin
      idx = IW'(rnd) * IW'(NMUL) + IW'(m);
      op  = '0;
      if (int'(idx) < NPAIR) op = diff_r[idx];
      mul_q[m] = square_mag(op);
    end
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_sq
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sq[p] <= '0;
      else if (busy && rnd == RW'(p / NMUL)) sq[p] <= mul_q[p % NMUL];
    end
  end

  // R8
  step_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !busy);
  // R8
  seq_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (busy && rnd == '0));
endmodule

// File: rtl/disp_cost_sum.sv
module disp_cost_sum
  import ssd_pkg::*;
#(
  parameter int WIN   = 11,
  parameter int NC    = 8,
  parameter int CW    = 21,
  parameter int NPAIR = WIN * NC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          v_in,
  input  sq_t           sq   [NPAIR],
  output logic [CW-1:0] cost [NC],
  output logic          v_out
);
  localparam int MAXC = WIN * ((1 << PIX_W) - 1) * ((1 << PIX_W) - 1);

  // stage 4: one adder chain per candidate
  for (genvar c = 0; c < NC; c++) begin : g_sum
    logic [CW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int w = 0; w < WIN; w++) acc = acc + CW'(sq[c*WIN+w]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cost[c] <= '0;
      else if (step) cost[c] <= acc;
    end
    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      v_out |-> (cost[c] <= CW'(MAXC)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    v_out <= 1'b0;
    else if (step) v_out <= v_in;
  end
endmodule

// File: rtl/disp_argmin.sv
module disp_argmin #(
  parameter int NC = 8,
  parameter int CW = 21,
  parameter int DW = $clog2(NC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          v_in,
  input  logic [CW-1:0] cost [NC],
  output logic [DW-1:0] disp,
  output logic          disp_valid
);
  localparam int NP = 1 << $clog2(NC);
  localparam int NN = 2 * NP - 1;

  logic [CW-1:0] hc [NN];
  logic [DW-1:0] hi [NN];
  logic [CW-1:0] win_cost;

  // leaves: padded slots carry the largest cost and never win
  for (genvar i = 0; i < NP; i++) begin : g_leaf
    if (i < NC) begin : g_real
      assign hc[NP-1+i] = cost[i];
    end else begin : g_pad
      assign hc[NP-1+i] = '1;
    end
    assign hi[NP-1+i] = DW'(i);
  end

  // stage 5: heap-ordered tree; left child holds lower codes, wins ties
  for (genvar n = 0; n < NP - 1; n++) begin : g_node
    logic take_r;
    assign take_r = hc[2*n+2] < hc[2*n+1];
    assign hc[n]  = take_r ? hc[2*n+2] : hc[2*n+1];
    assign hi[n]  = take_r ? hi[2*n+2] : hi[2*n+1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp       <= '0;
      disp_valid <= 1'b0;
      win_cost   <= '0;
    end else if (step) begin
      disp       <= hi[0];
      win_cost   <= hc[0];
      disp_valid <= v_in;
    end else begin
      disp_valid <= 1'b0;
    end
  end

  for (genvar i = 0; i < NC; i++) begin : g_chk
    // R3
    min_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> (win_cost <= $past(cost[i])));
    // R4
    tie_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && i < int'(disp)) |-> (win_cost < $past(cost[i])));
  end

  // R5
  dv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> !disp_valid);
endmodule

// File: rtl/ssd_disparity.sv
module ssd_disparity
  import ssd_pkg::*;
#(
  parameter int WIN  = 11,
  parameter int BETA = 4,
  parameter int NMUL = 12,
  parameter int DW   = $clog2(2 * BETA)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pixel_valid,
  input  logic          start_of_frame,
  input  logic [7:0]    left_pix,
  input  logic [7:0]    right_pix,
  output logic          disp_valid,
  output logic [DW-1:0] disp
);
  localparam int D     = WIN - 1 + 2 * BETA;
  localparam int NC    = 2 * BETA;
  localparam int NPAIR = WIN * NC;
  localparam int CW    = $clog2(WIN * ((1 << PIX_W) - 1) * ((1 << PIX_W) - 1)) + 1;

  pix_t          lh [D];
  pix_t          rh [D];
  sq_t           sq [NPAIR];
  logic [CW-1:0] cost [NC];
  logic          hist_full, v_sq, v_cost, sq_busy;

  disp_hist #(.D(D)) u_hist (
    .clk(clk), .rst_n(rst_n), .step(pixel_valid), .sof(start_of_frame),
    .lpix(left_pix), .rpix(right_pix), .lh(lh), .rh(rh), .full(hist_full)
  );

  disp_sq_engine #(.WIN(WIN), .BETA(BETA), .NMUL(NMUL), .D(D), .NC(NC), .NPAIR(NPAIR)) u_sq (
    .clk(clk), .rst_n(rst_n), .step(pixel_valid), .v_in(hist_full),
    .lh(lh), .rh(rh), .sq(sq), .v_out(v_sq), .busy(sq_busy)
  );

  disp_cost_sum #(.WIN(WIN), .NC(NC), .CW(CW), .NPAIR(NPAIR)) u_sum (
    .clk(clk), .rst_n(rst_n), .step(pixel_valid), .v_in(v_sq),
    .sq(sq), .cost(cost), .v_out(v_cost)
  );

  disp_argmin #(.NC(NC), .CW(CW), .DW(DW)) u_min (
    .clk(clk), .rst_n(rst_n), .step(pixel_valid), .v_in(v_cost),
    .cost(cost), .disp(disp), .disp_valid(disp_valid)
  );

  // R8
  busy_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_busy |-> !pixel_valid);
endmodule

// File: tb/sim_ssd_disparity.sv
module sim_ssd_disparity;
  localparam int WIN  = 11;
  localparam int BETA = 4;
  localparam int H    = (WIN - 1) / 2;
  localparam int D    = WIN - 1 + 2 * BETA;
  localparam int GAP  = 9;
  localparam int MAXN = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pixel_valid = 1'b0;
  logic       start_of_frame = 1'b0;
  logic [7:0] left_pix = '0;
  logic [7:0] right_pix = '0;
  logic       disp_valid;
  logic [2:0] disp;

  int gl [MAXN];
  int gr [MAXN];
  int fillv [MAXN];
  int nstep = 0;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ssd_disparity #(.WIN(WIN), .BETA(BETA), .NMUL(12)) u0 (
    .clk(clk), .rst_n(rst_n), .pixel_valid(pixel_valid), .start_of_frame(start_of_frame),
    .left_pix(left_pix), .right_pix(right_pix), .disp_valid(disp_valid), .disp(disp)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected code for history ending at global pixel n (R2, R3, R4)
  function automatic int model_code(input int n);
    int best = -1;
    int bc = 0;
    for (int j = -BETA; j < BETA; j++) begin
      int c = 0;
      for (int t = -H; t <= H; t++) begin
        int k;
        int a;
        k = n - H - BETA + 1;
        a = gl[k+t] - gr[k+t+j];
        c += a * a;
      end
      if (best < 0 || c < bc) begin
        bc = c;
        best = j + BETA;
      end
    end
    return best;
  endfunction

  task automatic push(input int l, input int r, input bit sof, input int gap);
    int s;
    int held;
    @(negedge clk);
    pixel_valid = 1'b1; start_of_frame = sof;
    left_pix = 8'(l); right_pix = 8'(r);
    s = nstep;
    gl[s] = l; gr[s] = r;
    if (sof || s == 0) fillv[s] = 1;
    else fillv[s] = (fillv[s-1] >= D) ? D : fillv[s-1] + 1;
    nstep++;
    @(negedge clk);
    pixel_valid = 1'b0; start_of_frame = 1'($urandom);
    left_pix = 8'($urandom); right_pix = 8'($urandom);
    if (s >= 3 && fillv[s-3] == D) begin
      chk(disp_valid === 1'b1, "R5/R6 valid pulse", int'(disp_valid), 1);
      chk(int'(disp) == model_code(s-3), "R2/R3/R4 code", int'(disp), model_code(s-3));
    end else begin
      chk(disp_valid === 1'b0, "R6 no early valid", int'(disp_valid), 0);
    end
    held = int'(disp);
    for (int g = 1; g < gap; g++) begin
      @(negedge clk);
      start_of_frame = 1'($urandom);
      left_pix = 8'($urandom); right_pix = 8'($urandom);
    end
    // R9: idle inputs ignored, output held, pulse over
    chk(disp_valid === 1'b0 && int'(disp) == held, "R9 idle hold", int'(disp), held);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int seed;
    int v;
    seed = int'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1
    chk(disp_valid === 1'b0, "R1 reset valid", int'(disp_valid), 0);
    chk(disp === 3'd0, "R1 reset disp", int'(disp), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(disp_valid === 1'b0 && disp === 3'd0, "R1 after release", int'(disp), 0);

    // random textured frame, varied gaps (R8 minimum gap included)
    for (int i = 0; i < 50; i++) push(int'($urandom % 256), int'($urandom % 256), i == 0, GAP + int'($urandom % 5));

    // shifted copy: right leads left by known offsets (R3)
    for (int sh = -BETA; sh < BETA; sh += 3) begin
      int base;
      base = nstep;
      for (int i = 0; i < 40; i++) begin
        v = int'($urandom % 256);
        gl[base+i] = v;
      end
      for (int i = 0; i < 40; i++) begin
        int src;
        int l;
        l = gl[base+i];
        src = i - sh;
        push(l, (src >= 0 && src < 40) ? gl[base+src] : int'($urandom % 256), i == 0, GAP);
      end
    end

    // flat frame: every cost equal, lowest code must win (R4)
    for (int i = 0; i < 30; i++) push(100, 100, i == 0, GAP);

    // full-scale alternating contrast (R2 width)
    for (int i = 0; i < 30; i++) push((i % 2) ? 255 : 0, (i % 2) ? 0 : 255, i == 0, GAP);

    // short frame cut by an early start_of_frame (R6, R7)
    for (int i = 0; i < 10; i++) push(int'($urandom % 256), int'($urandom % 256), i == 0, GAP);
    for (int i = 0; i < 40; i++) push(int'($urandom % 256), int'($urandom % 256), i == 0, GAP + int'($urandom % 3));

    finish_run();
  end
endmodule